// File: doc/BRIEF.md
# Fixed-Latency Read Return Tracker

This block sits on the memory-controller side of a DDR PHY link and handles the read path. For every accepted read command it drives two per-byte read enables toward the PHY. The first rises with the command. The second is the same pulse train moved later by the CAS latency plus any registered-DIMM delay. The PHY returns read data with no valid qualifier, so the block works out for itself when each beat arrives. A programmed, fixed latency is counted from the command.

Every enabled data cycle sends a marker, carrying the command's tag, down a 32-stage delay pipeline. When a marker reaches the stage selected by the latency setting, the read data bus is sampled in that cycle. The sampled word goes upstream with a one-cycle valid flag and the tag.

A new read that arrives while a burst is still running cuts that burst short. Beats that were never enabled are never expected and never delivered. The timing settings are copied into the block only while the PHY reports that it is not initialised. A read issued in that state is refused and flagged.

Top module: `rd_return_tracker`

## Requirements
- R1: While reset is asserted and right after it, both enable buses, `rd_valid`, `rd_data` and `cmd_err` are all zero.
- R2: An accepted command (`rd_cmd` high while `init_done` is high) sets every bit of `rden_unsh` high. This starts on the clock edge that samples the command and lasts for the burst length in cycles. All byte bits carry the same value.
- R3: `rden_sh` equals `rden_unsh` delayed by `cas_dly` cycles (0 to 15). A value of 0 makes the two buses identical.
- R4: The command is sampled at edge E, and `lat_code` is the 5-bit value v. Beat j of the burst is captured from `phy_rdata` at edge E+v+1+j, so the latency runs from 1 to 32 cycles. In the cycle after that edge, `rd_valid` is high, `rd_data` holds the sampled word and `rd_tag_o` holds the command's `rd_tag`. In any other cycle `rd_valid` is low.
- R5: With `ddr2_mode` high, an odd `rd_len` is rounded up to the next even count (15 gives 16). With `ddr2_mode` low, any length from 1 to 15 is used as given.
- R6: An accepted command that arrives during a running burst ends the earlier burst's enable at once. The new burst then runs for its full length under its own tag. Beats of the cut burst that were never enabled produce no `rd_valid`.
- R7: `cas_dly` and `lat_code` are taken into the block only in cycles where `init_done` is low. Changing them while `init_done` is high does not move the enables or the capture.
- R8: `rd_cmd` while `init_done` is low is ignored: no enable and no capture follow it. `cmd_err` is high for exactly the one cycle after the sampling edge.
- R9: Take a burst of 4 words (2 enable cycles) with `cas_dly`=4 and `lat_code`=8. `rden_sh` is high in cycles 4 and 5 after the command, and the beats are captured at latency 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| init_done | input | 1 | PHY ready; settings are frozen while high |
| ddr2_mode | input | 1 | 1 = round odd lengths up to even |
| cas_dly | input | 4 | Shifted-enable delay in cycles (CAS + DIMM) |
| lat_code | input | 5 | Read return latency minus one |
| rd_cmd | input | 1 | Read command strobe |
| rd_len | input | 4 | Data cycles expected for the command |
| rd_tag | input | 4 | Command tag |
| phy_rdata | input | 32 | Read data from the PHY, no qualifier |
| rden_unsh | output | 2 | Per-byte enable aligned with the command |
| rden_sh | output | 2 | Per-byte enable delayed by `cas_dly` |
| rd_valid | output | 1 | Captured beat present |
| rd_data | output | 32 | Captured beat |
| rd_tag_o | output | 4 | Tag of the captured beat |
| cmd_err | output | 1 | Read refused because the PHY was not ready |

## Verification
The bench uses the default parameters: two DRAM bytes at a 2:1 data ratio (a 32-bit read bus), a 4-bit length, a 4-bit delay, a 5-bit latency and a 4-bit tag. With the full 32-stage marker pipeline and the 15-stage delay line, both extremes can be reached: latency 1 with no shift, and latency 32 with a shift of 15. A 15-beat request in DDR2 mode tests the rounding into the extra counter bit that reaches 16. Interrupted bursts in both modes check truncation and the handover of tags in the capture stream.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  parameter int unsigned RRT_TAG_W = 4;

  typedef struct packed {
    logic                 vld;
    logic [RRT_TAG_W-1:0] tag;
  } beat_t;
endpackage

// File: rtl/rrt_en_gen.sv
module rrt_en_gen #(
  parameter int unsigned NB   = 2,
  parameter int unsigned LENW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic                          ddr2,
  input  logic [LENW-1:0]               len,
  input  logic [rrt_pkg::RRT_TAG_W-1:0] tag,
  output logic [NB-1:0]                 en_q,
  output rrt_pkg::beat_t                beat_o
);
  localparam int unsigned CW   = LENW + 1;
  localparam int unsigned TAGW = rrt_pkg::RRT_TAG_W;

  logic [CW-1:0]   cnt_q, cnt_d, eff_len;
  logic [TAGW-1:0] tag_q, tag_d;
  logic            run_d;

  always_comb begin
    eff_len = {1'b0, len} + CW'(ddr2 & len[0]);
    cnt_d   = cnt_q;
    tag_d   = tag_q;
    if (accept) begin
      cnt_d = eff_len;
      tag_d = tag;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
    run_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (accept) tag_q <= tag_d;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[b] <= 1'b0;
      else        en_q[b] <= run_d;
    end
  end

  assign beat_o.vld = en_q[0];
  assign beat_o.tag = tag_q;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && len != '0) |=> en_q[0]);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(1 << LENW));
endmodule

// File: rtl/rrt_en_delay.sv
module rrt_en_delay #(
  parameter int unsigned SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_in,
  input  logic [SELW-1:0] sel,
  output logic            en_out
);
  localparam int unsigned MAXD = (1 << SELW) - 1;

  logic [MAXD:1] sh_q;
  logic [MAXD:0] taps;

  assign taps   = {sh_q, en_in};
  assign en_out = taps[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= taps[MAXD-1:0];
  end
endmodule

// File: rtl/rrt_capture.sv
module rrt_capture #(
  parameter int unsigned LATW = 5,
  parameter int unsigned DW   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  rrt_pkg::beat_t                beat_in,
  input  logic [LATW-1:0]               lat_code,
  input  logic [DW-1:0]                 rdata,
  output logic                          valid_q,
  output logic [DW-1:0]                 data_q,
  output logic [rrt_pkg::RRT_TAG_W-1:0] tag_q
);
  localparam int unsigned DEPTH = 1 << LATW;

  rrt_pkg::beat_t pipe_q [1:DEPTH-1];
  rrt_pkg::beat_t sel;

  always_comb begin
    sel = beat_in;
    for (int i = 1; i < DEPTH; i++) begin
      if (lat_code == LATW'(i)) sel = pipe_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[1] <= beat_in;
      for (int i = 2; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= '0;
    end else begin
      valid_q <= sel.vld;
      if (sel.vld) begin
        data_q <= rdata;
        tag_q  <= sel.tag;
      end
    end
  end
endmodule

// File: rtl/rd_return_tracker.sv
module rd_return_tracker #(
  parameter int unsigned NB    = 2,
  parameter int unsigned RATIO = 2,
  parameter int unsigned LENW  = 4,
  parameter int unsigned CASW  = 4,
  parameter int unsigned LATW  = 5,
  parameter int unsigned TAGW  = rrt_pkg::RRT_TAG_W,
  parameter int unsigned DW    = 8 * NB * RATIO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_done,
  input  logic            ddr2_mode,
  input  logic [CASW-1:0] cas_dly,
  input  logic [LATW-1:0] lat_code,
  input  logic            rd_cmd,
  input  logic [LENW-1:0] rd_len,
  input  logic [TAGW-1:0] rd_tag,
  input  logic [DW-1:0]   phy_rdata,
  output logic [NB-1:0]   rden_unsh,
  output logic [NB-1:0]   rden_sh,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [TAGW-1:0] rd_tag_o,
  output logic            cmd_err
);
  logic [CASW-1:0] cfg_cas;
  logic [LATW-1:0] cfg_lat;
  logic            accept, err_d;
  rrt_pkg::beat_t  beat;

  assign accept = rd_cmd & init_done;
  assign err_d  = rd_cmd & ~init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cas <= '0;
      cfg_lat <= '0;
      cmd_err <= 1'b0;
    end else begin
      if (!init_done) begin
        cfg_cas <= cas_dly;
        cfg_lat <= lat_code;
      end
      cmd_err <= err_d;
    end
  end

  rrt_en_gen #(.NB(NB), .LENW(LENW)) u_gen (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ddr2(ddr2_mode),
    .len(rd_len), .tag(rd_tag), .en_q(rden_unsh), .beat_o(beat)
  );

  for (genvar b = 0; b < NB; b++) begin : g_shift
    rrt_en_delay #(.SELW(CASW)) u_dly (
      .clk(clk), .rst_n(rst_n), .en_in(rden_unsh[b]),
      .sel(cfg_cas), .en_out(rden_sh[b])
    );
  end

  rrt_capture #(.LATW(LATW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .beat_in(beat), .lat_code(cfg_lat),
    .rdata(phy_rdata), .valid_q(rd_valid), .data_q(rd_data), .tag_q(rd_tag_o)
  );

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !init_done) |=> cmd_err);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |-> ($stable(cfg_lat) && $stable(cfg_cas)));

  p_zero_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cas == '0) |-> (rden_sh == rden_unsh));
endmodule

// File: tb/sim_rd_return_tracker.sv
module sim_rd_return_tracker;
  localparam int NB = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n, init_done, ddr2_mode, rd_cmd;
  logic [3:0] cas_dly, rd_len, rd_tag;
  logic [4:0] lat_code;
  logic [DW-1:0] phy_rdata;
  logic [NB-1:0] rden_unsh, rden_sh;
  logic rd_valid, cmd_err;
  logic [DW-1:0] rd_data;
  logic [3:0] rd_tag_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rd_return_tracker u0 (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .ddr2_mode(ddr2_mode),
    .cas_dly(cas_dly), .lat_code(lat_code), .rd_cmd(rd_cmd), .rd_len(rd_len),
    .rd_tag(rd_tag), .phy_rdata(phy_rdata), .rden_unsh(rden_unsh), .rden_sh(rden_sh),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag_o(rd_tag_o), .cmd_err(cmd_err)
  );

  // fields: ddr2, cas, lat_code, len1, tag1, gap(0 = none), len2, tag2
  localparam int NV = 8;
  localparam int VEC [NV][8] = '{
    '{0, 4,  8,  2, 1, 0, 0, 0},   // R9 example
    '{0, 0,  0,  1, 2, 0, 0, 0},   // R4 minimum latency, R3 zero shift
    '{0, 15, 31, 5, 3, 0, 0, 0},   // R4 maximum latency, R3 maximum shift
    '{1, 2,  5,  3, 4, 0, 0, 0},   // R5 odd length rounded in DDR2 mode
    '{0, 3,  6,  7, 5, 0, 0, 0},   // R5 odd length kept in DDR1 mode
    '{0, 3,  6,  4, 6, 2, 4, 7},   // R6 interrupt
    '{1, 1,  4,  8, 8, 3, 8, 9},   // R6 interrupt in DDR2 mode
    '{1, 1,  10, 15, 11, 0, 0, 0}  // R5 15 rounds to 16
  };

  int s_len1, s_len2, s_gap, s_tag1, s_tag2, s_cas, s_lat, s_base;

  function automatic int eff(int d2, int n);
    return (d2 != 0 && (n % 2) == 1) ? n + 1 : n;
  endfunction

  function automatic bit en_at(int k);
    bit a, b;
    if (k < 0) return 1'b0;
    a = (k < s_len1) && (s_gap == 0 || k < s_gap);
    b = (s_gap != 0) && (k >= s_gap) && (k < s_gap + s_len2);
    return a | b;
  endfunction

  function automatic int tag_at(int k);
    return (s_gap != 0 && k >= s_gap) ? s_tag2 : s_tag1;
  endfunction

  function automatic logic [DW-1:0] pat(int k);
    return 32'hC0DE0000 ^ DW'(s_base + k + 7);
  endfunction

  task automatic report(input string req, input bit ok, input string what,
                        input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int d2, input int cas, input int lat, input int len1,
                     input int tag1, input int gap, input int len2, input int tag2,
                     input int lat_late, input int base, input string req);
    bit ok_u = 1, ok_s = 1, ok_c = 1;
    int au = 0, eu = 0, as_ = 0, es = 0, ac = 0, ec = 0;
    s_len1 = eff(d2, len1); s_len2 = eff(d2, len2); s_gap = gap;
    s_tag1 = tag1; s_tag2 = tag2; s_cas = cas; s_lat = lat + 1; s_base = base;
    @(negedge clk);
    init_done = 0; ddr2_mode = d2[0]; cas_dly = 4'(cas); lat_code = 5'(lat); rd_cmd = 0;
    repeat (3) @(negedge clk);
    init_done = 1;
    @(negedge clk);
    lat_code = 5'(lat_late);
    rd_cmd = 1; rd_len = 4'(len1); rd_tag = 4'(tag1); phy_rdata = pat(-1);
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      if (ok_u && rden_unsh !== {NB{en_at(k)}}) begin
        ok_u = 0; au = int'(rden_unsh); eu = en_at(k) ? 3 : 0;
      end
      if (ok_s && rden_sh !== {NB{en_at(k - s_cas)}}) begin
        ok_s = 0; as_ = int'(rden_sh); es = en_at(k - s_cas) ? 3 : 0;
      end
      if (ok_c) begin
        if (rd_valid !== en_at(k - s_lat)) begin
          ok_c = 0; ac = int'(rd_valid); ec = int'(en_at(k - s_lat));
        end else if (rd_valid && (rd_data !== pat(k - 1))) begin
          ok_c = 0; ac = int'(rd_data); ec = int'(pat(k - 1));
        end else if (rd_valid && (int'(rd_tag_o) != tag_at(k - s_lat))) begin
          ok_c = 0; ac = int'(rd_tag_o); ec = tag_at(k - s_lat);
        end
      end
      rd_cmd = (gap != 0 && k == gap - 1);
      if (rd_cmd) begin rd_len = 4'(len2); rd_tag = 4'(tag2); end
      phy_rdata = pat(k);
    end
    report({req, " R2 unshifted"}, ok_u, "rden_unsh", au, eu);
    report({req, " R3 shifted"}, ok_s, "rden_sh", as_, es);
    report({req, " R4 capture"}, ok_c, "rd_valid/data/tag", ac, ec);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; init_done = 0; ddr2_mode = 0; cas_dly = 0; lat_code = 0;
    rd_cmd = 0; rd_len = 0; rd_tag = 0; phy_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    report("R1", {rden_unsh, rden_sh, rd_valid, cmd_err} == '0 && rd_data == '0,
           "outputs in reset", int'({rden_unsh, rden_sh, rd_valid, cmd_err}), 0);
    rst_n = 1;
    @(negedge clk);
    report("R1", {rden_unsh, rden_sh, rd_valid, cmd_err} == '0,
           "outputs after reset", int'({rden_unsh, rden_sh, rd_valid, cmd_err}), 0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
          VEC[v][5], VEC[v][6], VEC[v][7], VEC[v][2], v * 256,
          (v == 0) ? "R9" : (v >= 5 && v <= 6) ? "R6" : (v >= 3) ? "R5" : "R4");
    end

    // R7: latency moved while ready has no effect (configured code 4, driven 10)
    run(0, 2, 4, 3, 12, 0, 0, 0, 10, 4096, "R7");

    // R8: command while not ready
    @(negedge clk);
    init_done = 0; rd_cmd = 1; rd_len = 4; rd_tag = 13;
    @(negedge clk);
    rd_cmd = 0;
    report("R8", cmd_err === 1'b1, "cmd_err pulse", int'(cmd_err), 1);
    report("R8", rden_unsh === '0, "no enable", int'(rden_unsh), 0);
    @(negedge clk);
    report("R8", cmd_err === 1'b0, "cmd_err one cycle", int'(cmd_err), 0);
    begin
      bit seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (rd_valid || rden_unsh != '0 || rden_sh != '0) seen = 1;
      end
      report("R8", !seen, "no activity after refused read", int'(seen), 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule